// File: doc/BRIEF.md
# Read Data Error Capture Unit

This block sits on the read-return side of a memory traffic generator. Each cycle it may receive an expected data word and a read data word, each with its own valid strobe, together with the address of the read. When both strobes are high it compares the two words bit by bit. A mismatch raises a one-cycle error flag with the failing bits and address, and it updates several kinds of error record. One record holds the first failure. Another accumulates every failing bit over time. Two saturating counters count failure events.

The sequencer uses the block in two ways. With checking enabled, the first failure raises a stop request. The sequencer then runs a read-back retest and reports its verdict through a result input, and the block stores that verdict as the error type. A rising edge on the continue input drops the stop request. There are two clear inputs, and both act on rising edges. One wipes all error state except the accumulated sticky record. The other wipes the sticky record as well.

Top module: `rdec_capture`

## Requirements
- R1: A compare takes place only in a cycle in which `exp_vld` and `rd_vld` are both high. `mis_vld` is high in the cycle after such a compare if and only if the two words differed, and it is low after any cycle without a compare.
- R2: On a compare, `mis_bits` takes `exp_data ^ rd_data` (a 1 marks a failing bit) and `mis_addr` takes `rd_addr`, one clock later. Both keep their values until the next compare or clear.
- R3: `mis_cnt` increments once for each compare that mismatches. It saturates at all ones (CNT_W bits, default 32) instead of wrapping.
- R4: With `chk_en` high, the first mismatching compare loads `first_bits`, `first_addr`, `first_exp` and `first_rd` and sets `first_vld`. These registers do not change again until a clear.
- R5: Every mismatching compare ORs its failing bits into `stk_bits` and sets `stk_vld`. Neither is reduced except by a clear-all.
- R6: `stk_cnt` increments on each mismatching compare that arrives while `stk_vld` is already high. It saturates like `mis_cnt`.
- R7: A rising edge on `clr_in` zeroes `mis_vld`, `mis_bits`, `mis_addr`, `mis_cnt`, the first-error record, the error type and `stop_req`. It leaves `stk_vld`, `stk_bits` and `stk_cnt` unchanged. Holding `clr_in` high has no further effect.
- R8: A rising edge on `clr_all_in` zeroes everything R7 zeroes and also the sticky record and `stk_cnt`.
- R9: A clear edge takes priority over a compare in the same cycle: the mismatch is not flagged or counted.
- R10: `stop_req` rises together with `first_vld` when `chk_en` is high. It falls on a rising edge of `cont_in` or on a clear. It never rises while `chk_en` is low.
- R11: When `rtest_vld` is high and no type is held, `etype` stores `rtest_is_rd` (0 = write error, 1 = read error) and `etype_vld` goes high. The type is held until a clear.
- R12: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_en | input | 1 | Enable first-error capture and stop |
| clr_in | input | 1 | Clear except sticky (rising edge) |
| clr_all_in | input | 1 | Clear including sticky (rising edge) |
| cont_in | input | 1 | Release stop request (rising edge) |
| exp_vld | input | 1 | Expected data valid |
| exp_data | input | DATA_W | Expected data |
| rd_vld | input | 1 | Read data valid |
| rd_data | input | DATA_W | Read data |
| rd_addr | input | ADDR_W | Read address |
| rtest_vld | input | 1 | Retest verdict valid |
| rtest_is_rd | input | 1 | Retest verdict: 1 read error, 0 write error |
| mis_vld | output | 1 | Mismatch on last compare |
| mis_bits | output | DATA_W | Failing bit vector |
| mis_addr | output | ADDR_W | Failing address |
| mis_cnt | output | CNT_W | Saturating mismatch count |
| first_vld | output | 1 | First-error record valid |
| first_bits | output | DATA_W | First failing bit vector |
| first_addr | output | ADDR_W | First failing address |
| first_exp | output | DATA_W | Expected word of first failure |
| first_rd | output | DATA_W | Read word of first failure |
| stk_vld | output | 1 | Sticky record valid |
| stk_bits | output | DATA_W | Accumulated failing bits |
| stk_cnt | output | CNT_W | Saturating sticky count |
| etype_vld | output | 1 | Error type valid |
| etype | output | 1 | Error type: 1 read, 0 write |
| stop_req | output | 1 | Stop request to the sequencer |

## Verification
Most state in this block is a visible output, so a wrong internal value shows at the ports on the clock after the compare or clear that produced it. The edge detectors are the exception. A stale previous-level bit either fires a second clear while an input is held high, or misses a clear. That error appears one cycle later, as an unexpected drop in `mis_cnt` or as error state that stays set. A counter that wraps appears only after saturation, so the bench overrides the counter width to reach it. Priority errors between a clear and a compare in the same cycle appear as a nonzero `mis_vld` on the next cycle.

// File: rtl/rdec_pkg.sv
package rdec_pkg;

  typedef enum logic {
    ETYPE_WRITE = 1'b0,
    ETYPE_READ  = 1'b1
  } etype_e;

  localparam int unsigned EDGE_N   = 3;
  localparam int unsigned EDGE_CLR = 0;
  localparam int unsigned EDGE_ALL = 1;
  localparam int unsigned EDGE_CNT = 2;

endpackage

// File: rtl/rdec_edge.sv
module rdec_edge #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);

  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic prev_d;
    always_comb prev_d = lvl_i[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= prev_d;
    end

    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end

endmodule

// File: rtl/rdec_sat_cnt.sv
module rdec_sat_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr | (inc & (cnt != MAX));
    if (clr) cnt_d = '0;
    else     cnt_d = cnt + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAX && !clr) |=> (cnt == MAX)); // R3

endmodule

// File: rtl/rdec_cmp.sv
module rdec_cmp #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              exp_vld,
  input  logic [DATA_W-1:0] exp_data,
  input  logic              rd_vld,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              mis_now,
  output logic [DATA_W-1:0] diff,
  output logic              mis_vld,
  output logic [DATA_W-1:0] mis_bits,
  output logic [ADDR_W-1:0] mis_addr
);

  logic              fire;
  logic              vld_d;
  logic [DATA_W-1:0] bits_d;
  logic [ADDR_W-1:0] addr_d;
  logic              load_en;

  always_comb begin
    fire    = exp_vld & rd_vld;
    diff    = exp_data ^ rd_data;
    mis_now = fire & (|diff);
  end

  always_comb begin
    load_en = clr | fire;
    vld_d   = 1'b0;
    bits_d  = mis_bits;
    addr_d  = mis_addr;
    if (clr) begin
      bits_d = '0;
      addr_d = '0;
    end else if (fire) begin
      vld_d  = mis_now;
      bits_d = diff;
      addr_d = rd_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mis_vld <= 1'b0;
    else        mis_vld <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mis_bits <= '0;
      mis_addr <= '0;
    end else if (load_en) begin
      mis_bits <= bits_d;
      mis_addr <= addr_d;
    end
  end

  AST_NO_CMP_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !(exp_vld && rd_vld) |=> !mis_vld); // R1

endmodule

// File: rtl/rdec_capture.sv
module rdec_capture
  import rdec_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_en,
  input  logic              clr_in,
  input  logic              clr_all_in,
  input  logic              cont_in,
  input  logic              exp_vld,
  input  logic [DATA_W-1:0] exp_data,
  input  logic              rd_vld,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rtest_vld,
  input  logic              rtest_is_rd,
  output logic              mis_vld,
  output logic [DATA_W-1:0] mis_bits,
  output logic [ADDR_W-1:0] mis_addr,
  output logic [CNT_W-1:0]  mis_cnt,
  output logic              first_vld,
  output logic [DATA_W-1:0] first_bits,
  output logic [ADDR_W-1:0] first_addr,
  output logic [DATA_W-1:0] first_exp,
  output logic [DATA_W-1:0] first_rd,
  output logic              stk_vld,
  output logic [DATA_W-1:0] stk_bits,
  output logic [CNT_W-1:0]  stk_cnt,
  output logic              etype_vld,
  output logic              etype,
  output logic              stop_req
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sq;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_sn = rst_sq[1];

  // rising-edge detection of the control levels
  logic [EDGE_N-1:0] lvl;
  logic [EDGE_N-1:0] rise;
  logic              clr_rise;
  logic              clr_all_rise;
  logic              cont_rise;
  logic              clr_any;

  always_comb begin
    lvl           = '0;
    lvl[EDGE_CLR] = clr_in;
    lvl[EDGE_ALL] = clr_all_in;
    lvl[EDGE_CNT] = cont_in;
  end

  rdec_edge #(.N(EDGE_N)) u_edge (
    .clk    (clk),
    .rst_n  (rst_sn),
    .lvl_i  (lvl),
    .rise_o (rise)
  );

  always_comb begin
    clr_rise     = rise[EDGE_CLR];
    clr_all_rise = rise[EDGE_ALL];
    cont_rise    = rise[EDGE_CNT];
    clr_any      = clr_rise | clr_all_rise;
  end

  // per-beat compare
  logic              mis_now;
  logic [DATA_W-1:0] diff;

  rdec_cmp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_sn),
    .clr      (clr_any),
    .exp_vld  (exp_vld),
    .exp_data (exp_data),
    .rd_vld   (rd_vld),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .mis_now  (mis_now),
    .diff     (diff),
    .mis_vld  (mis_vld),
    .mis_bits (mis_bits),
    .mis_addr (mis_addr)
  );

  // counters
  logic mis_inc;
  logic stk_inc;

  always_comb begin
    mis_inc = mis_now & ~clr_any;
    stk_inc = mis_now & stk_vld & ~clr_all_rise;
  end

  rdec_sat_cnt #(.W(CNT_W)) u_mis_cnt (
    .clk   (clk),
    .rst_n (rst_sn),
    .clr   (clr_any),
    .inc   (mis_inc),
    .cnt   (mis_cnt)
  );

  rdec_sat_cnt #(.W(CNT_W)) u_stk_cnt (
    .clk   (clk),
    .rst_n (rst_sn),
    .clr   (clr_all_rise),
    .inc   (stk_inc),
    .cnt   (stk_cnt)
  );

  // first-error record
  logic              first_load;
  logic              first_en;
  logic              first_vld_d;
  logic [DATA_W-1:0] first_bits_d;
  logic [ADDR_W-1:0] first_addr_d;
  logic [DATA_W-1:0] first_exp_d;
  logic [DATA_W-1:0] first_rd_d;

  always_comb begin
    first_load   = chk_en & mis_now & ~first_vld & ~clr_any;
    first_en     = clr_any | first_load;
    first_vld_d  = first_load;
    first_bits_d = first_load ? diff     : '0;
    first_addr_d = first_load ? rd_addr  : '0;
    first_exp_d  = first_load ? exp_data : '0;
    first_rd_d   = first_load ? rd_data  : '0;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      first_vld  <= 1'b0;
      first_bits <= '0;
      first_addr <= '0;
      first_exp  <= '0;
      first_rd   <= '0;
    end else if (first_en) begin
      first_vld  <= first_vld_d;
      first_bits <= first_bits_d;
      first_addr <= first_addr_d;
      first_exp  <= first_exp_d;
      first_rd   <= first_rd_d;
    end
  end

  // sticky accumulation
  logic              stk_en;
  logic              stk_vld_d;
  logic [DATA_W-1:0] stk_bits_d;

  always_comb begin
    stk_en     = clr_all_rise | mis_now;
    stk_vld_d  = 1'b0;
    stk_bits_d = '0;
    if (!clr_all_rise) begin
      stk_vld_d  = 1'b1;
      stk_bits_d = stk_bits | diff;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      stk_vld  <= 1'b0;
      stk_bits <= '0;
    end else if (stk_en) begin
      stk_vld  <= stk_vld_d;
      stk_bits <= stk_bits_d;
    end
  end

  // stop request
  logic stop_d;

  always_comb begin
    stop_d = stop_req;
    if (clr_any)        stop_d = 1'b0;
    else if (first_load) stop_d = 1'b1;
    else if (cont_rise)  stop_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) stop_req <= 1'b0;
    else         stop_req <= stop_d;
  end

  // retest verdict
  logic   type_en;
  logic   etype_vld_d;
  etype_e etype_d;

  always_comb begin
    type_en     = clr_any | (rtest_vld & ~etype_vld);
    etype_vld_d = ~clr_any;
    etype_d     = clr_any ? ETYPE_WRITE : etype_e'(rtest_is_rd);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      etype_vld <= 1'b0;
      etype     <= ETYPE_WRITE;
    end else if (type_en) begin
      etype_vld <= etype_vld_d;
      etype     <= etype_d;
    end
  end

  AST_FIRST_FROZEN: assert property (@(posedge clk) disable iff (!rst_sn)
    (first_vld && !clr_any) |=> ($stable(first_bits) && $stable(first_addr))); // R4

  AST_STICKY_GROWS: assert property (@(posedge clk) disable iff (!rst_sn)
    !clr_all_rise |=> ((stk_bits & $past(stk_bits)) == $past(stk_bits))); // R5

  AST_CLR_SPARES_STICKY: assert property (@(posedge clk) disable iff (!rst_sn)
    (clr_rise && !clr_all_rise && stk_vld) |=> stk_vld); // R7

  AST_NO_STOP_UNCHECKED: assert property (@(posedge clk) disable iff (!rst_sn)
    (!stop_req && !chk_en) |=> !stop_req); // R10

  AST_TYPE_HELD: assert property (@(posedge clk) disable iff (!rst_sn)
    (etype_vld && !clr_any) |=> (etype_vld && $stable(etype))); // R11

endmodule

// File: tb/rdec_capture_bench.sv
module rdec_capture_bench;

  localparam int CLK_P = 10;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic chk_en, clr_in, clr_all_in, cont_in;
  logic exp_vld, rd_vld, rtest_vld, rtest_is_rd;
  logic [DW-1:0] exp_data, rd_data;
  logic [AW-1:0] rd_addr;
  logic mis_vld, first_vld, stk_vld, etype_vld, etype, stop_req;
  logic [DW-1:0] mis_bits, first_bits, first_exp, first_rd, stk_bits;
  logic [AW-1:0] mis_addr, first_addr;
  logic [CW-1:0] mis_cnt, stk_cnt;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  rdec_capture #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW)) u_rdec_capture (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .clr_in(clr_in),
    .clr_all_in(clr_all_in), .cont_in(cont_in), .exp_vld(exp_vld),
    .exp_data(exp_data), .rd_vld(rd_vld), .rd_data(rd_data), .rd_addr(rd_addr),
    .rtest_vld(rtest_vld), .rtest_is_rd(rtest_is_rd), .mis_vld(mis_vld),
    .mis_bits(mis_bits), .mis_addr(mis_addr), .mis_cnt(mis_cnt),
    .first_vld(first_vld), .first_bits(first_bits), .first_addr(first_addr),
    .first_exp(first_exp), .first_rd(first_rd), .stk_vld(stk_vld),
    .stk_bits(stk_bits), .stk_cnt(stk_cnt), .etype_vld(etype_vld),
    .etype(etype), .stop_req(stop_req)
  );

  typedef struct packed {
    logic          ev;
    logic          rv;
    logic [DW-1:0] e;
    logic [DW-1:0] r;
    logic [AW-1:0] a;
    logic          xm;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 8'hA5, 8'hA5, 8'h10, 1'b0},
    '{1'b1, 1'b1, 8'hA5, 8'hA4, 8'h11, 1'b1},
    '{1'b1, 1'b0, 8'h00, 8'hFF, 8'h12, 1'b0},
    '{1'b0, 1'b1, 8'h00, 8'hFF, 8'h13, 1'b0},
    '{1'b1, 1'b1, 8'h0F, 8'hF0, 8'h14, 1'b1},
    '{1'b1, 1'b1, 8'h3C, 8'h3C, 8'h15, 1'b0},
    '{1'b1, 1'b1, 8'h80, 8'h00, 8'h16, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic ev, input logic rv, input logic [DW-1:0] e,
                       input logic [DW-1:0] r, input logic [AW-1:0] a);
    exp_vld = ev; rd_vld = rv; exp_data = e; rd_data = r; rd_addr = a;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    int m_cnt, s_cnt;
    logic s_vld;
    logic [DW-1:0] s_bits;
    rst_n = 1'b0; chk_en = 0; clr_in = 0; clr_all_in = 0; cont_in = 0;
    rtest_vld = 0; rtest_is_rd = 0;
    drive(0, 0, '0, '0, '0);
    repeat (3) tick();
    // R12 reset state
    check("R12 mis_vld", mis_vld, 0);
    check("R12 mis_cnt", mis_cnt, 0);
    check("R12 stk_bits", stk_bits, 0);
    check("R12 first_vld", first_vld, 0);
    check("R12 stop_req", stop_req, 0);
    rst_n = 1'b1;
    repeat (4) tick();

    // table walk, checking disabled
    m_cnt = 0; s_cnt = 0; s_vld = 0; s_bits = '0;
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].ev, VECS[i].rv, VECS[i].e, VECS[i].r, VECS[i].a);
      tick();
      check("R1 mis_vld", mis_vld, VECS[i].xm);
      if (VECS[i].xm) begin
        check("R2 mis_bits", mis_bits, VECS[i].e ^ VECS[i].r);
        check("R2 mis_addr", mis_addr, VECS[i].a);
        if (s_vld && s_cnt < 7) s_cnt++;
        if (m_cnt < 7) m_cnt++;
        s_vld = 1; s_bits |= VECS[i].e ^ VECS[i].r;
      end
    end
    drive(0, 0, '0, '0, '0);
    check("R3 mis_cnt", mis_cnt, m_cnt);
    check("R5 stk_bits", stk_bits, s_bits);
    check("R5 stk_vld", stk_vld, s_vld);
    check("R6 stk_cnt", stk_cnt, s_cnt);
    check("R10 no stop unchecked", stop_req, 0);
    check("R4 no snapshot unchecked", first_vld, 0);

    // R7 clear keeps sticky
    clr_in = 1; tick();
    check("R7 mis_cnt", mis_cnt, 0);
    check("R7 mis_bits", mis_bits, 0);
    check("R7 stk_bits", stk_bits, 8'hFF);
    check("R7 stk_cnt", stk_cnt, 2);
    // R7 level held: no second clear
    drive(1, 1, 8'h55, 8'h54, 8'h30); tick();
    check("R7 held level", mis_cnt, 1);
    check("R6 stk_cnt", stk_cnt, 3);
    clr_in = 0;

    // R4 / R10 first error with checking
    chk_en = 1;
    drive(1, 1, 8'h11, 8'h10, 8'h20); tick();
    check("R4 first_vld", first_vld, 1);
    check("R4 first_bits", first_bits, 8'h01);
    check("R4 first_addr", first_addr, 8'h20);
    check("R4 first_exp", first_exp, 8'h11);
    check("R4 first_rd", first_rd, 8'h10);
    check("R10 stop set", stop_req, 1);
    drive(1, 1, 8'h22, 8'h20, 8'h21); tick();
    check("R4 first held", first_bits, 8'h01);
    check("R4 addr held", first_addr, 8'h20);
    check("R2 mis_bits", mis_bits, 8'h02);
    check("R10 stop held", stop_req, 1);
    drive(0, 0, '0, '0, '0); cont_in = 1; tick();
    check("R10 stop released", stop_req, 0);
    drive(1, 1, 8'h44, 8'h40, 8'h22); tick();
    check("R10 no restop", stop_req, 0);
    drive(0, 0, '0, '0, '0); cont_in = 0;

    // R11 error type
    rtest_vld = 1; rtest_is_rd = 1; tick();
    check("R11 etype_vld", etype_vld, 1);
    check("R11 etype", etype, 1);
    rtest_is_rd = 0; tick();
    check("R11 etype held", etype, 1);
    rtest_vld = 0;

    // R8 clear all
    clr_all_in = 1; tick();
    check("R8 stk_vld", stk_vld, 0);
    check("R8 stk_bits", stk_bits, 0);
    check("R8 stk_cnt", stk_cnt, 0);
    check("R8 first_vld", first_vld, 0);
    check("R8 etype_vld", etype_vld, 0);
    check("R8 mis_cnt", mis_cnt, 0);
    clr_all_in = 0;

    // R3 / R6 saturation, checking off
    chk_en = 0;
    for (int k = 0; k < 9; k++) begin
      drive(1, 1, 8'h01, 8'h00, 8'h40); tick();
    end
    check("R3 saturate", mis_cnt, 7);
    check("R6 saturate", stk_cnt, 7);
    check("R10 no stop unchecked", stop_req, 0);
    drive(0, 0, '0, '0, '0); tick();

    // R9 clear wins over compare
    clr_in = 1; drive(1, 1, 8'hFF, 8'h00, 8'h50); tick();
    check("R9 mis_vld", mis_vld, 0);
    check("R9 mis_cnt", mis_cnt, 0);
    clr_in = 0; drive(0, 0, '0, '0, '0); tick();

    summary();
  end

endmodule